// File: doc/BRIEF.md
# Token-Ring Interleaved Conversion Sequencer

This block sequences a bank of identical successive-approximation conversion channels that all run from one shared clock at the full aggregate sample rate. A single token circulates around a ring, one channel per clock. The channel that holds the token is in its sample cycle. In each of the following cycles it resolves one bit of its code by binary search: it presents a trial word to its comparator and keeps or clears the trial bit according to the comparator decision that comes back. With one sample cycle plus one cycle per bit, the channel count equals the code width plus one. Each channel therefore gets the token again on the same edge that ends its last bit cycle.

Finished codes are merged into one output stream that carries a code, the index of the channel that produced it, and a valid strobe. Once the pipeline has filled, the stream delivers one code per clock in the order the samples were taken. Every sampling instant comes straight from the shared clock through a single token register, so no multiphase clock generator and no skew correction are involved. A ring that ever holds no token or more than one token is flagged and forced back to a single token at channel 0.

Top module: `ring_sar_sequencer`

## Requirements
- R1: While reset is asserted, only channel 0 is in its sample cycle (`chSample` = 1), `outValid` is 0 and `tokenErr` is 0.
- R2: After reset, exactly one bit of `chSample` is set in every cycle.
- R3: The sample cycle moves from channel k to channel (k+1) mod NUM_CH on every rising clock edge, starting from channel 0 on the first edge after reset is released.
- R4: The trial word of a channel is 0 during its sample cycle. In its first bit cycle, the cycle after sampling, the trial word is only the MSB (16 for 5-bit codes).
- R5: With an ideal comparator (`chCmp[k]` = 1 when the held input is at or above the trial word in `chTrial[k*CODE_W +: CODE_W]`), each code equals the sampled input level from 0 to 2^CODE_W-1, including both ends of the range.
- R6: `outValid` is 0 for the first NUM_CH-1 edges after reset is released. It rises on edge NUM_CH and stays at 1 on every later cycle.
- R7: Output codes leave in sample order: `outCh` counts 0,1,...,NUM_CH-1 and wraps to 0. Each code belongs to the sample taken NUM_CH edges earlier.
- R8: `tokenErr` is 1 only when the ring holds other than exactly one token. It stays 0 in normal operation, and a faulty ring is re-seeded to channel 0.
- R9: The comparator input of a channel is ignored during that channel's sample cycle and has no effect on any code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock at the aggregate sample rate |
| rstN | input | 1 | Active-low synchronous reset |
| chCmp | input | NUM_CH | Comparator decision per channel, 1 = input at or above trial word |
| chSample | output | NUM_CH | One-hot sample-cycle strobe per channel (token position) |
| chTrial | output | NUM_CH*CODE_W | Trial word per channel, channel k in bits k*CODE_W and up |
| outValid | output | 1 | Output code valid |
| outCode | output | CODE_W | Finished conversion code |
| outCh | output | CH_W | Index of the channel that produced `outCode` |
| tokenErr | output | 1 | Ring holds zero or several tokens |

## Verification
The bench builds the block with the default CODE_W of 5, which gives six channels and a 3-bit channel index. This setting exercises the full code range 0 to 31 and the index wrap from 5 back to 0, where the index values 6 and 7 must never appear. Random comparator noise during each channel's sample cycle and a reset in the middle of the run test that stray decisions are ignored and that the start-up latency repeats after a second fill.

// File: rtl/rss_pkg.sv
package rss_pkg;

  // Width of the bit-select field; supports codes of up to 16 bits.
  localparam int SEL_W = 4;

  // Per-channel strobes passed from the control to the datapath.
  typedef struct packed {
    logic             sample;  // channel holds the token this cycle
    logic             decide;  // channel is resolving a bit this cycle
    logic             last;    // this cycle resolves the LSB
    logic [SEL_W-1:0] bitSel;  // bit position resolved this cycle
  } chanStb_t;

endpackage

// File: rtl/rss_ctrl.sv
module rss_ctrl
  import rss_pkg::*;
#(
  parameter  int CODE_W = 5,
  localparam int NUM_CH = CODE_W + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  output chanStb_t [NUM_CH-1:0]  stb,
  output logic [NUM_CH-1:0]      tokenOut,
  output logic                   tokenErr
);

  localparam int PH_W = $clog2(CODE_W + 1);
  localparam logic [NUM_CH-1:0] SEED = NUM_CH'(1);

  logic [NUM_CH-1:0] tokenQ;
  logic              ringBad;

  assign ringBad  = !$onehot(tokenQ);
  assign tokenErr = ringBad;
  assign tokenOut = tokenQ;

  // Token ring: one hop per clock, re-seeded at channel 0 on a fault.
  always_ff @(posedge clk) begin
    if (!rstN)        tokenQ <= SEED;
    else if (ringBad) tokenQ <= SEED;
    else              tokenQ <= {tokenQ[NUM_CH-2:0], tokenQ[NUM_CH-1]};
  end

  // Per-channel phase: 0 = sample/idle, 1..CODE_W = bit cycles MSB first.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_phase
    logic [PH_W-1:0] phaseQ;

    always_ff @(posedge clk) begin
      if (!rstN)                                     phaseQ <= '0;
      else if (tokenQ[g])                            phaseQ <= PH_W'(1);
      else if (phaseQ != '0 && phaseQ < PH_W'(CODE_W)) phaseQ <= phaseQ + PH_W'(1);
      else                                           phaseQ <= '0;
    end

    always_comb begin
      stb[g].sample = tokenQ[g];
      stb[g].decide = (phaseQ != '0) && !tokenQ[g];
      stb[g].last   = stb[g].decide && (phaseQ == PH_W'(CODE_W));
      stb[g].bitSel = SEL_W'(CODE_W) - SEL_W'(phaseQ);
    end
  end

endmodule

// File: rtl/rss_datapath.sv
module rss_datapath
  import rss_pkg::*;
#(
  parameter  int CODE_W = 5,
  localparam int NUM_CH = CODE_W + 1,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  chanStb_t [NUM_CH-1:0]      stb,
  input  logic [NUM_CH-1:0]          chCmp,
  output logic [NUM_CH*CODE_W-1:0]   chTrial,
  output logic                       outValid,
  output logic [CODE_W-1:0]          outCode,
  output logic [CH_W-1:0]            outCh
);

  logic [NUM_CH-1:0][CODE_W-1:0] sarNext;

  // Successive-approximation register per channel.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_sar
    logic [CODE_W-1:0] sarQ;
    logic [CODE_W-1:0] bitMask;

    assign bitMask    = CODE_W'(1) << stb[g].bitSel;
    assign sarNext[g] = (sarQ & ~bitMask) | (chCmp[g] ? bitMask : '0);

    assign chTrial[g*CODE_W +: CODE_W] =
        stb[g].sample ? '0 :
        stb[g].decide ? (sarQ | bitMask) : sarQ;

    always_ff @(posedge clk) begin
      if (!rstN)              sarQ <= '0;
      else if (stb[g].sample) sarQ <= '0;
      else if (stb[g].decide) sarQ <= sarNext[g];
    end
  end

  // Round-robin merge: at most one channel finishes per cycle.
  logic              anyDone;
  logic [CODE_W-1:0] selCode;
  logic [CH_W-1:0]   selCh;

  always_comb begin
    anyDone = 1'b0;
    selCode = '0;
    selCh   = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (stb[k].last) begin
        anyDone = 1'b1;
        selCode = selCode | sarNext[k];
        selCh   = selCh | CH_W'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outCode  <= '0;
      outCh    <= '0;
    end else begin
      outValid <= anyDone;
      outCode  <= selCode;
      outCh    <= selCh;
    end
  end

endmodule

// File: rtl/ring_sar_sequencer.sv
module ring_sar_sequencer
  import rss_pkg::*;
#(
  parameter  int CODE_W = 5,
  localparam int NUM_CH = CODE_W + 1,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CH-1:0]         chCmp,
  output logic [NUM_CH-1:0]         chSample,
  output logic [NUM_CH*CODE_W-1:0]  chTrial,
  output logic                      outValid,
  output logic [CODE_W-1:0]         outCode,
  output logic [CH_W-1:0]           outCh,
  output logic                      tokenErr
);

  chanStb_t [NUM_CH-1:0] stb;

  rss_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .tokenOut (chSample),
    .tokenErr (tokenErr)
  );

  rss_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .chCmp    (chCmp),
    .chTrial  (chTrial),
    .outValid (outValid),
    .outCode  (outCode),
    .outCh    (outCh)
  );

endmodule

// File: rtl/rss_checker.sv
module rss_checker #(
  parameter  int CODE_W = 5,
  localparam int NUM_CH = CODE_W + 1,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_CH-1:0]         chSample,
  input logic [NUM_CH*CODE_W-1:0]  chTrial,
  input logic                      outValid,
  input logic [CH_W-1:0]           outCh,
  input logic                      tokenErr
);

  localparam int CNT_W = $clog2(NUM_CH + 1);

  logic [CNT_W-1:0]  fillCnt;
  logic [NUM_CH-1:0] rotNext;
  logic [CH_W-1:0]   chNext;

  always_ff @(posedge clk) begin
    if (!rstN)                        fillCnt <= '0;
    else if (fillCnt < CNT_W'(NUM_CH)) fillCnt <= fillCnt + CNT_W'(1);
  end

  assign rotNext = {chSample[NUM_CH-2:0], chSample[NUM_CH-1]};
  assign chNext  = (outCh == CH_W'(NUM_CH - 1)) ? '0 : outCh + CH_W'(1);

  a_r2_one_sampler: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(chSample));

  a_r3_token_rotates: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> chSample == $past(rotNext));

  a_r6_fill_latency: assert property (@(posedge clk) disable iff (!rstN)
    outValid == (fillCnt == CNT_W'(NUM_CH)));

  a_r7_channel_order: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid || outCh == $past(chNext));

  a_r8_no_token_fault: assert property (@(posedge clk) disable iff (!rstN)
    !tokenErr);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_trial
    a_r4_sample_trial_zero: assert property (@(posedge clk) disable iff (!rstN)
      chSample[g] |-> chTrial[g*CODE_W +: CODE_W] == '0);
  end

endmodule

bind ring_sar_sequencer rss_checker #(.CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .chSample (chSample),
  .chTrial  (chTrial),
  .outValid (outValid),
  .outCh    (outCh),
  .tokenErr (tokenErr)
);

// File: tb/ring_sar_sequencer_tb.sv
`timescale 1ns/1ps
module ring_sar_sequencer_tb;

  localparam int CODE_W = 5;
  localparam int NUM_CH = CODE_W + 1;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int QMASK  = 1023;

  logic                      clk = 1'b0;
  logic                      rstN = 1'b0;
  logic [NUM_CH-1:0]         chCmp;
  logic [NUM_CH-1:0]         chSample;
  logic [NUM_CH*CODE_W-1:0]  chTrial;
  logic                      outValid;
  logic [CODE_W-1:0]         outCode;
  logic [CH_W-1:0]           outCh;
  logic                      tokenErr;

  int          held [NUM_CH];
  logic [NUM_CH-1:0] noise = '0;
  int          expCode [QMASK+1];
  int          expCh   [QMASK+1];
  int          wr, rd;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ring_sar_sequencer #(.CODE_W(CODE_W)) u_dut (
    .clk(clk), .rstN(rstN), .chCmp(chCmp), .chSample(chSample),
    .chTrial(chTrial), .outValid(outValid), .outCode(outCode),
    .outCh(outCh), .tokenErr(tokenErr)
  );

  // Ideal comparator per channel; noise while the channel samples (R9).
  always_comb begin
    for (int k = 0; k < NUM_CH; k++) begin
      if (chSample[k]) chCmp[k] = noise[k];
      else             chCmp[k] = int'(chTrial[k*CODE_W +: CODE_W]) <= held[k];
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int trialOf(int k);
    return int'(chTrial[k*CODE_W +: CODE_W]);
  endfunction

  function automatic int stimOf(int n, int mode);
    int dir [8] = '{0, 31, 16, 15, 1, 30, 0, 31};
    if (n < 8) return dir[n];
    if (mode == 1 && n < 40) return (n % 2 == 1) ? 31 : 0;
    return int'($urandom % 32);
  endfunction

  task automatic resetHold(int cycles);
    rstN = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); @(negedge clk);
      chk(chSample == NUM_CH'(1), "R1 sample", int'(chSample), 1);
      chk(outValid == 1'b0, "R1 valid", int'(outValid), 0);
      chk(tokenErr == 1'b0, "R1 tokenErr", int'(tokenErr), 0);
    end
  endtask

  task automatic runPhase(int cycles, int mode);
    rstN = 1'b1;
    wr = 0; rd = 0;
    for (int j = 0; j < cycles; j++) begin
      int cur = j % NUM_CH;
      int val;
      if (j < NUM_CH) begin
        chk(outValid == 1'b0, "R6 fill", int'(outValid), 0);
      end else begin
        chk(outValid == 1'b1, "R6 steady", int'(outValid), 1);
        chk(int'(outCode) == expCode[rd & QMASK], "R5 R9 code", int'(outCode), expCode[rd & QMASK]);
        chk(int'(outCh) == expCh[rd & QMASK], "R7 order", int'(outCh), expCh[rd & QMASK]);
        rd++;
      end
      chk(chSample == NUM_CH'(1 << cur), "R3 token", int'(chSample), 1 << cur);
      chk($countones(chSample) == 1, "R2 onehot", $countones(chSample), 1);
      chk(trialOf(cur) == 0, "R4 sample trial", trialOf(cur), 0);
      if (j >= 1) begin
        int prev = (j - 1) % NUM_CH;
        chk(trialOf(prev) == (1 << (CODE_W - 1)), "R4 msb trial",
            trialOf(prev), 1 << (CODE_W - 1));
      end
      chk(tokenErr == 1'b0, "R8 tokenErr", int'(tokenErr), 0);
      val = stimOf(j, mode);
      held[cur] = val;
      expCode[wr & QMASK] = val;
      expCh[wr & QMASK] = cur;
      wr++;
      noise = NUM_CH'($urandom);
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd4321));
    for (int k = 0; k < NUM_CH; k++) held[k] = 0;
    @(negedge clk);
    resetHold(3);
    runPhase(600, 1);
    // Reset in mid-stream: state returns to R1 and the fill repeats (R6).
    resetHold(2);
    runPhase(400, 2);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R6 actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule